// File: doc/BRIEF.md
# Phase-Programmable Serial Frame Master

This block is a synchronous serial master that moves one word of 4 to 32 bits per frame, most significant bit first. A one-cycle start request latches the word, the length, the clock polarity, the clock phase and a divider. The block then pulls its active-low frame strobe down, toggles the serial clock and shifts the word out on the transmit line, while it shifts the receive line in. When the frame ends it presents the received word, right-aligned, together with a one-cycle done pulse.

The frame is built from half periods of the serial clock. Each half period lasts a programmable number of system clocks. The phase bit controls where the idle gaps fall. With phase 0 the clock rests for a full period after the strobe falls and for half a period before it rises. With phase 1 it rests for half a period at the start and a full period at the end. Polarity and phase together select which clock edge launches data and which edge captures it. The transmit line is held low whenever no frame is running.

Top module: `sfm_top`

## Requirements
- R1: After reset, and whenever no frame is active, `frame_n_o` is 1, `busy_o` is 0, `mosi_o` is 0 and `sclk_o` rests at the polarity latched for the last frame (0 after reset).
- R2: A start accepted at a clock edge drives `frame_n_o` low from that edge. It stays low for exactly (2N+2)·D system clocks, where N is the word length and D is the half-period length. `busy_o` is the inverse of `frame_n_o`.
- R3: The size field holds N−1. Values below 3 are treated as 3, so the word is 4 bits.
- R4: Number the half periods k = 0 to 2N+1 from the fall of the strobe. With phase 0 the clock is at its active level (the inverse of the polarity) in the even slots 2 to 2N and idle in all other slots.
- R5: With phase 1 the clock is active in the odd slots 1 to 2N−1 and idle in all other slots.
- R6: The polarity bit sets the idle level, and it inverts the whole clock waveform.
- R7: The transmit line carries word bit N−1 in slots 0 and 1. It carries bit N−1−j in slots 2j+1 and 2j+2, and 0 in slot 2N+1. Data therefore changes on the falling clock edge when polarity equals phase, and on the rising edge when they differ.
- R8: The receive line is sampled only at the end of slots 1, 3, …, 2N−1. These are the rising edges when polarity equals phase, and the falling edges when they differ. All other receive values are ignored. The received word is right-aligned, MSB first, with the bits above N−1 at zero.
- R9: `done_o` is high for exactly one clock, on the clock where `frame_n_o` returns high, and `rx_word_o` holds the received word at that time.
- R10: A start request while `busy_o` is 1 is ignored. The frame in progress keeps the word and settings latched at its start.
- R11: A divider input of 0 is treated as 1, meaning one system clock per half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start request |
| tx_word_i | input | DATA_W | Word to transmit, right-aligned |
| size_i | input | $clog2(DATA_W) | Word length minus one |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Clock phase select |
| div_i | input | DIV_W | System clocks per half period |
| miso_i | input | 1 | Serial receive data |
| sclk_o | output | 1 | Serial clock |
| frame_n_o | output | 1 | Active-low frame strobe |
| mosi_o | output | 1 | Serial transmit data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rx_word_o | output | DATA_W | Received word, right-aligned |

## Verification
Every output is registered, so an accepted start shows on the strobe, clock and data one clock later. Each later half-period slot shows D clocks after the one before it. The done pulse and the received word appear (2N+2)·D clocks after the strobe falls. The bench expands each accepted frame into one expected output vector per system clock and compares the ports with that vector on every falling edge. The clock-level and data-bit timing are therefore checked at the exact cycle where they are due. A slave model counts capture edges on the serial clock and changes the receive line only after each edge it has seen. It drives 1 outside the valid bit window, so any sample taken in the wrong slot would corrupt the expected word.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } sfm_mode_t;

  // Active-level test for half-period slot k of an nbits frame.
  function automatic logic slot_active(input int unsigned k,
                                       input int unsigned nbits,
                                       input logic        cpha);
    if (cpha)
      return (k >= 1) && (k <= 2 * nbits - 1) && (k % 2 == 1);
    else
      return (k >= 2) && (k <= 2 * nbits) && (k % 2 == 0);
  endfunction

endpackage

// File: rtl/sfm_half_timer.sv
module sfm_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load_i || tick_o) cnt_q <= '0;
    else if (run_i)           cnt_q <= cnt_q + DIV_W'(1);
  end

  // R11
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt_q < div_i));
endmodule

// File: rtl/sfm_slot_ctrl.sv
module sfm_slot_ctrl #(
  parameter int SLOT_W = 7,
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              tick_i,
  input  logic              busy_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] next_slot_o,
  output logic              fin_o
);
  logic [SLOT_W-1:0] last_slot;

  assign last_slot   = (SLOT_W'(size_i) << 1) + SLOT_W'(3);
  assign next_slot_o = slot_o + SLOT_W'(1);
  assign fin_o       = tick_i && (slot_o == last_slot);

  always_ff @(posedge clk) begin
    if (rst)         slot_o <= '0;
    else if (load_i) slot_o <= '0;
    else if (tick_i) slot_o <= next_slot_o;
  end

  // R2
  slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> (slot_o <= last_slot));
endmodule

// File: rtl/sfm_clk_shape.sv
module sfm_clk_shape #(
  parameter int SLOT_W = 7,
  parameter int SIZE_W = 5
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SIZE_W-1:0] size_i,
  input  sfm_pkg::sfm_mode_t mode_i,
  output logic              level_o
);
  logic active;

  always_comb begin
    active  = sfm_pkg::slot_active(int'(slot_i), int'(size_i) + 1, mode_i.cpha);
    level_o = mode_i.cpol ^ active;
  end
endmodule

// File: rtl/sfm_shifter.sv
module sfm_shifter #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 5,
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic [SIZE_W-1:0] load_size_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              tick_i,
  input  logic              fin_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] next_slot_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic              tx_adv;
  logic              rx_take;

  assign tx_adv  = tick_i && next_slot_i[0] && (next_slot_i >= SLOT_W'(3));
  assign rx_take = tick_i && slot_i[0] &&
                   (slot_i <= ((SLOT_W'(size_i) << 1) | SLOT_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr  <= '0;
      mosi_o <= 1'b0;
    end else if (load_i) begin
      tx_sr  <= tx_i << (SIZE_W'(DATA_W - 1) - load_size_i);
      mosi_o <= tx_i[load_size_i];
    end else if (fin_i) begin
      mosi_o <= 1'b0;
    end else if (tx_adv) begin
      tx_sr  <= tx_sr << 1;
      mosi_o <= tx_sr[DATA_W-2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr <= '0;
      rx_o  <= '0;
    end else begin
      if (load_i)       rx_sr <= '0;
      else if (rx_take) rx_sr <= {rx_sr[DATA_W-2:0], miso_i};
      if (fin_i)        rx_o  <= rx_sr;
    end
  end

  // R7
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fin_i |=> !mosi_o);
endmodule

// File: rtl/sfm_top.sv
module sfm_top #(
  parameter int  DATA_W = 32,
  parameter int  DIV_W  = 8,
  localparam int SIZE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              frame_n_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int SLOT_W = $clog2(2 * DATA_W + 3);

  logic               accept;
  logic               busy_q;
  logic               frame_n_q;
  logic               done_q;
  logic               sclk_q;
  sfm_pkg::sfm_mode_t mode_q;
  logic [SIZE_W-1:0]  size_q;
  logic [SIZE_W-1:0]  size_c;
  logic [DIV_W-1:0]   div_q;
  logic               tick;
  logic               fin;
  logic [SLOT_W-1:0]  slot;
  logic [SLOT_W-1:0]  next_slot;
  logic               level;
  logic [DATA_W-1:0]  rx_mask;

  assign accept = start_i && !busy_q;
  assign size_c = (size_i < SIZE_W'(3)) ? SIZE_W'(3) : size_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      size_q <= SIZE_W'(3);
      div_q  <= DIV_W'(1);
    end else if (accept) begin
      mode_q <= '{cpol: cpol_i, cpha: cpha_i};
      size_q <= size_c;
      div_q  <= (div_i == '0) ? DIV_W'(1) : div_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      frame_n_q <= 1'b1;
      done_q    <= 1'b0;
      sclk_q    <= 1'b0;
    end else begin
      done_q <= fin;
      if (accept) begin
        busy_q    <= 1'b1;
        frame_n_q <= 1'b0;
        sclk_q    <= cpol_i;
      end else if (tick) begin
        sclk_q <= level;
        if (fin) begin
          busy_q    <= 1'b0;
          frame_n_q <= 1'b1;
        end
      end
    end
  end

  sfm_half_timer #(.DIV_W(DIV_W)) i_timer (
    .clk(clk), .rst(rst), .load_i(accept), .run_i(busy_q),
    .div_i(div_q), .tick_o(tick)
  );

  sfm_slot_ctrl #(.SLOT_W(SLOT_W), .SIZE_W(SIZE_W)) i_slots (
    .clk(clk), .rst(rst), .load_i(accept), .tick_i(tick), .busy_i(busy_q),
    .size_i(size_q), .slot_o(slot), .next_slot_o(next_slot), .fin_o(fin)
  );

  sfm_clk_shape #(.SLOT_W(SLOT_W), .SIZE_W(SIZE_W)) i_shape (
    .slot_i(next_slot), .size_i(size_q), .mode_i(mode_q), .level_o(level)
  );

  sfm_shifter #(.DATA_W(DATA_W), .SIZE_W(SIZE_W), .SLOT_W(SLOT_W)) i_shift (
    .clk(clk), .rst(rst), .load_i(accept), .tx_i(tx_word_i),
    .load_size_i(size_c), .size_i(size_q), .tick_i(tick), .fin_i(fin),
    .slot_i(slot), .next_slot_i(next_slot), .miso_i(miso_i),
    .mosi_o(mosi_o), .rx_o(rx_word_o)
  );

  assign sclk_o    = sclk_q;
  assign frame_n_o = frame_n_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_mask   = {DATA_W{1'b1}} >> (SIZE_W'(DATA_W - 1) - size_q);

  // R2
  busy_frame_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o != frame_n_o);
  // R1
  idle_mosi_chk: assert property (@(posedge clk) disable iff (rst)
    frame_n_o |-> !mosi_o);
  // R6
  idle_sclk_chk: assert property (@(posedge clk) disable iff (rst)
    frame_n_o |-> (sclk_o == mode_q.cpol));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9
  done_frame_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> frame_n_o);
  // R8
  rx_upper_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((rx_word_o & ~rx_mask) == '0));
  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !fin) |=> ($stable(mode_q) && $stable(size_q) && $stable(div_q)));
endmodule

// File: tb/test_sfm_top.sv
module test_sfm_top;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 8;
  localparam int SIZE_W = $clog2(DATA_W);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [DATA_W-1:0] tx_word_i = '0;
  logic [SIZE_W-1:0] size_i = '0;
  logic              cpol_i = 1'b0;
  logic              cpha_i = 1'b0;
  logic [DIV_W-1:0]  div_i = '0;
  logic              miso_i = 1'b1;
  logic              sclk_o, frame_n_o, mosi_o, busy_o, done_o;
  logic [DATA_W-1:0] rx_word_o;

  always #4 clk = ~clk;

  sfm_top #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_sfm_top (
    .clk(clk), .rst(rst), .start_i(start_i), .tx_word_i(tx_word_i),
    .size_i(size_i), .cpol_i(cpol_i), .cpha_i(cpha_i), .div_i(div_i),
    .miso_i(miso_i), .sclk_o(sclk_o), .frame_n_o(frame_n_o), .mosi_o(mosi_o),
    .busy_o(busy_o), .done_o(done_o), .rx_word_o(rx_word_o)
  );

  int checks = 0;
  int errors = 0;
  string scen = "reset";

  // Expected entry: {frame_n, sclk, mosi, done, rx}
  logic [DATA_W+3:0] q[$];
  logic idle_sclk = 1'b0;
  logic exp_busy  = 1'b0;
  logic [DATA_W-1:0] slv_word = '0;
  int   slv_n = 4;
  int   slv_cnt = 0;
  logic slv_rise = 1'b1;
  logic prev_sclk = 1'b0;
  logic prev_frame = 1'b1;

  task automatic check(input logic ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s [%s] actual=%h expected=%h", req, what, scen, act, exp);
    end
  endtask

  function automatic void push_frame(input logic [DATA_W-1:0] tx, input int sz,
                                     input logic pol, input logic pha, input int dv,
                                     input logic [DATA_W-1:0] slave);
    int n = (sz < 3) ? 4 : sz + 1;   // R3
    int d = (dv == 0) ? 1 : dv;      // R11
    logic [DATA_W-1:0] mask = (n == DATA_W) ? '1 : ((DATA_W'(1) << n) - 1);
    for (int k = 0; k <= 2 * n + 1; k++) begin
      logic act;
      logic m;
      int j = (k == 0) ? 0 : (k - 1) / 2;
      act = pha ? (k >= 1 && k <= 2 * n - 1 && k % 2 == 1)
                : (k >= 2 && k <= 2 * n && k % 2 == 0);
      m = (j < n) ? tx[n - 1 - j] : 1'b0;
      for (int r = 0; r < d; r++) q.push_back({1'b0, pol ^ act, m, 1'b0, {DATA_W{1'b0}}});
    end
    q.push_back({1'b1, pol, 1'b0, 1'b1, slave & mask});
    idle_sclk = pol;
    slv_word  = slave;
    slv_n     = n;
    slv_rise  = (pol == pha);
  endfunction

  task automatic step();
    logic [DATA_W+3:0] e;
    if (start_i && !exp_busy)
      push_frame(tx_word_i, int'(size_i), cpol_i, cpha_i, int'(div_i), slv_word_next);
    @(negedge clk);
    e = (q.size() != 0) ? q.pop_front() : {1'b1, idle_sclk, 1'b0, 1'b0, {DATA_W{1'b0}}};
    check(frame_n_o === e[DATA_W+3], "R2", "frame_n", DATA_W'(frame_n_o), DATA_W'(e[DATA_W+3]));
    check(busy_o === !e[DATA_W+3], "R2", "busy", DATA_W'(busy_o), DATA_W'(!e[DATA_W+3]));
    check(sclk_o === e[DATA_W+2], cur_pha ? "R5/R6" : "R4/R6", "sclk",
          DATA_W'(sclk_o), DATA_W'(e[DATA_W+2]));
    check(mosi_o === e[DATA_W+1], e[DATA_W+3] ? "R1" : "R7", "mosi",
          DATA_W'(mosi_o), DATA_W'(e[DATA_W+1]));
    check(done_o === e[DATA_W], "R9", "done", DATA_W'(done_o), DATA_W'(e[DATA_W]));
    if (e[DATA_W]) check(rx_word_o === e[DATA_W-1:0], "R8", "rx_word", rx_word_o, e[DATA_W-1:0]);
    exp_busy = !e[DATA_W+3];
    // slave model: advance after each capture edge it sees
    if (prev_frame && !frame_n_o) slv_cnt = 0;
    else if (!frame_n_o && (sclk_o != prev_sclk) && (sclk_o == slv_rise)) slv_cnt++;
    prev_sclk  = sclk_o;
    prev_frame = frame_n_o;
    miso_i = (!frame_n_o && slv_cnt < slv_n) ? slv_word[slv_n - 1 - slv_cnt] : 1'b1;
  endtask

  logic [DATA_W-1:0] slv_word_next = '0;
  logic cur_pha = 1'b0;

  task automatic launch(input string name, input logic [DATA_W-1:0] tx, input int sz,
                        input logic pol, input logic pha, input int dv,
                        input logic [DATA_W-1:0] slave);
    scen = name;
    tx_word_i = tx; size_i = SIZE_W'(sz); cpol_i = pol; cpha_i = pha;
    div_i = DIV_W'(dv); slv_word_next = slave; cur_pha = pha;
    start_i = 1'b1;
    step();
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) step();
    repeat (3) step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state
    scen = "R1 reset";
    check(frame_n_o === 1'b1 && busy_o === 1'b0 && mosi_o === 1'b0 && sclk_o === 1'b0,
          "R1", "idle", {frame_n_o, busy_o, mosi_o, sclk_o}, 4'b1000);
    repeat (2) step();

    launch("R4 pol0 pha0 n8 d2", 32'h0000_00A5, 7, 1'b0, 1'b0, 2, 32'h0000_003C);
    drain();
    launch("R6 pol1 pha0 n16 d1", 32'hFFFF_9C31, 15, 1'b1, 1'b0, 1, 32'h0000_5AF0);
    drain();
    launch("R5 pol0 pha1 n32 d3", 32'hDEAD_BEEF, 31, 1'b0, 1'b1, 3, 32'h1234_5678);
    drain();
    launch("R5 R6 pol1 pha1 n4 d1", 32'h0000_0009, 3, 1'b1, 1'b1, 1, 32'hFFFF_FFF6);
    drain();
    // R3 size clamp, R11 divider zero
    launch("R3 R11 size0 div0", 32'h0000_000C, 0, 1'b0, 1'b1, 0, 32'h0000_0003);
    drain();
    // R10: a second start in mid-frame with other settings is ignored
    launch("R10 base frame", 32'h0000_0B6D, 11, 1'b0, 1'b0, 2, 32'h0000_0F0F);
    repeat (9) step();
    tx_word_i = 32'hFFFF_FFFF; size_i = 5'd31; cpol_i = 1'b1; cpha_i = 1'b1; div_i = 8'd5;
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    drain();
    // back-to-back: new start in the done cycle
    launch("R9 back-to-back A", 32'h0000_0071, 6, 1'b1, 1'b0, 1, 32'h0000_0055);
    while (!(q.size() == 1)) step();
    step();
    launch("R9 back-to-back B", 32'h0003_2A19, 18, 1'b0, 1'b1, 2, 32'h0007_1E3B);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired [%s]", scen);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule